// File: doc/BRIEF.md
# SD host command issue engine

This block sends a single SD/MMC command through a host controller that uses the standard SD host register layout, then waits for that command to finish. A client hands it a command index, a 32-bit argument, five abstract response-type flags and a data-present flag over a valid/ready handshake. The engine builds the transfer-mode and command register words from these inputs. It performs the register writes in a fixed order, with the command write last because that write launches the command. It then reads interrupt status in a loop until the command completes, an error shows up or a programmable poll budget runs out.

In the polling loop the engine also handles SDMA boundary stops. It clears the boundary bit, reads the DMA address register and writes the same value back, which resumes the transfer. The block reaches the controller through a simple register master port. Only one access is outstanding at a time, and the port carries byte, halfword and word sizes. The result is a one-cycle done pulse with an error flag and a timeout flag.

States:
- `S_IDLE`: ready for a request. A valid request moves the engine to `S_CLR`.
- `S_CLR`, `S_SIGEN`, `S_ARG`, `S_MODE`, `S_CMD`: one register write each. Every one of these states moves to the next when the bus acknowledges. `S_CMD` moves to `S_POLL`.
- `S_POLL`: reads interrupt status. From there the engine goes to:
  - `S_DONE` on the error bit, on completion or when the poll budget is used up;
  - `S_STATBK` on a boundary stop;
  - `S_POLL` again in every other case.
- `S_STATBK` moves to `S_DMARD`, which moves to `S_DMAWR`. From `S_DMAWR` the engine goes to `S_DONE` if the saved status completes the command or the budget is used up, and otherwise back to `S_POLL`.
- `S_DONE` lasts one cycle and returns to `S_IDLE`.

Top module: `sdcmd_issue_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and both `bus_req` and `done` are 0.
- R2: The engine accepts a request in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after the done pulse.
- R3: The first three accesses of a command are word writes (size code 2):
  - 0xFFFFFFFF to offset 0x30;
  - 0 to offset 0x38;
  - the argument to offset 0x08.
- R4: The fourth access is a halfword write (size code 1) to offset 0x0C. It writes 0x0000 when no data is present and 0x0037 when data is present. The value 0x0037 sets bits 0, 1, 2, 4 and 5.
- R5: The fifth access is a halfword write to offset 0x0E that launches the command.
  - The word written is index×256 plus an 8-bit flags value.
  - The response flags are bit0 present, bit1 long, bit2 CRC, bit3 busy and bit4 opcode.
  - The low two bits of the flags value are 0 when no response is present, else 1 when the response is long, else 3 when busy, else 2.
  - The flags value adds 0x08 for CRC, 0x10 for opcode and 0x20 for data present.
- R6: The engine then word-reads offset 0x30 repeatedly.
  - If busy or data is set, the command completes when status bit1 is 1. Otherwise it completes when status bit0 is 1.
  - On completion, `done` is raised with `done_err`=0 and `done_tmo`=0.
- R7: If a status read has bit15 set, the command ends with `done_err`=1 and `done_tmo`=0. This happens even if completion or boundary bits are also set, and no further access is made.
- R8: A status read with bit3 set and bit15 clear is followed by three accesses:
  - a word write of that status value to 0x30;
  - a word read of 0x00;
  - a word write of the value read back to 0x00.
  After these, the engine finishes if the saved status completes the command, and otherwise polls again.
- R9: A status read that neither errors nor completes counts as one poll. When the count reaches `timeout_limit`, the command ends with `done_err`=1 and `done_tmo`=1. A limit of 0 behaves like a limit of 1.
- R10: Only one access is outstanding at a time. While `bus_req` is 1 and `bus_ack` is 0, the access fields hold their values. Halfword data is placed in the low bits of `bus_wdata`.
- R11: `done` is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_index | input | 8 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp | input | 5 | Response-type flags (present, long, CRC, busy, opcode) |
| req_data | input | 1 | Command carries a data transfer |
| timeout_limit | input | TMO_W | Poll budget before timeout |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | output | ADDR_W | Register offset |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Command ended in error or timeout |
| done_tmo | output | 1 | Command ended by poll timeout |

## Verification
The bench builds the engine with ADDR_W=8 and TMO_W=4. The narrow poll counter makes the budget's edge values cheap to reach: a limit of 0 gives a single poll, and a limit of 3 ends after three empty polls. The bus responder stretches its acknowledge latency from zero to two cycles, which holds accesses open across several cycles. The status scripts cover these cases:
- a bit0 that must be ignored for busy commands;
- a boundary stop that arrives together with data-end;
- an error that arrives together with completion bits.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int OFF_DMA_ADDR = 8'h00;
    localparam int OFF_ARG      = 8'h08;
    localparam int OFF_XFER     = 8'h0C;
    localparam int OFF_CMD      = 8'h0E;
    localparam int OFF_ISTAT    = 8'h30;
    localparam int OFF_SIG_EN   = 8'h38;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int ST_CMD_END  = 0;
    localparam int ST_DATA_END = 1;
    localparam int ST_DMA_STOP = 3;
    localparam int ST_ERROR    = 15;

    typedef enum logic [3:0] {
        S_IDLE, S_CLR, S_SIGEN, S_ARG, S_MODE, S_CMD,
        S_POLL, S_STATBK, S_DMARD, S_DMAWR, S_DONE
    } state_t;
endpackage

// File: rtl/sdcmd_word_encoder.sv
module sdcmd_word_encoder (
    input  logic [7:0]  index,
    input  logic [4:0]  rsp,
    input  logic        data,
    output logic [15:0] cmd_word,
    output logic [15:0] mode_word,
    output logic        end_on_data
);
    logic [7:0] flags;

    always_comb begin
        flags = 8'h00;
        if (!rsp[0])      flags[1:0] = 2'd0;
        else if (rsp[1])  flags[1:0] = 2'd1;
        else if (rsp[3])  flags[1:0] = 2'd3;
        else              flags[1:0] = 2'd2;
        flags[3] = rsp[2];
        flags[4] = rsp[4];
        flags[5] = data;
    end

    assign cmd_word    = {index, flags};
    assign mode_word   = data ? 16'h0037 : 16'h0000;
    assign end_on_data = rsp[3] | data;
endmodule

// File: rtl/sdcmd_poll_timer.sv
module sdcmd_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/sdcmd_issue_engine.sv
module sdcmd_issue_engine
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_index,
    input  logic [31:0]       req_arg,
    input  logic [4:0]        req_rsp,
    input  logic              req_data,
    input  logic [TMO_W-1:0]  timeout_limit,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic              done_err,
    output logic              done_tmo
);
    state_t      state_q, state_d;
    logic [31:0] arg_q, stat_q, dma_q;
    logic [15:0] cmd_q, mode_q;
    logic        end_data_q, err_q, tmo_q;
    logic [15:0] enc_cmd, enc_mode;
    logic        enc_end;
    logic        tmr_last, tmr_inc, tmr_clr;
    logic        poll_hit, saved_hit, take;

    sdcmd_word_encoder u_enc (
        .index(req_index), .rsp(req_rsp), .data(req_data),
        .cmd_word(enc_cmd), .mode_word(enc_mode), .end_on_data(enc_end)
    );

    sdcmd_poll_timer #(.W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc),
        .limit(timeout_limit), .last(tmr_last)
    );

    assign take      = (state_q == S_IDLE) && req_valid;
    assign poll_hit  = end_data_q ? bus_rdata[ST_DATA_END] : bus_rdata[ST_CMD_END];
    assign saved_hit = end_data_q ? stat_q[ST_DATA_END] : stat_q[ST_CMD_END];
    assign tmr_clr   = (state_q == S_IDLE);
    assign tmr_inc   = bus_ack &&
        (((state_q == S_POLL) && !bus_rdata[ST_ERROR] && !bus_rdata[ST_DMA_STOP] && !poll_hit) ||
         ((state_q == S_DMAWR) && !saved_hit));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_CLR;
            S_CLR:    if (bus_ack) state_d = S_SIGEN;
            S_SIGEN:  if (bus_ack) state_d = S_ARG;
            S_ARG:    if (bus_ack) state_d = S_MODE;
            S_MODE:   if (bus_ack) state_d = S_CMD;
            S_CMD:    if (bus_ack) state_d = S_POLL;
            S_POLL: if (bus_ack) begin
                if (bus_rdata[ST_ERROR])         state_d = S_DONE;
                else if (bus_rdata[ST_DMA_STOP]) state_d = S_STATBK;
                else if (poll_hit || tmr_last)   state_d = S_DONE;
                else                             state_d = S_POLL;
            end
            S_STATBK: if (bus_ack) state_d = S_DMARD;
            S_DMARD:  if (bus_ack) state_d = S_DMAWR;
            S_DMAWR: if (bus_ack) begin
                if (saved_hit || tmr_last) state_d = S_DONE;
                else                       state_d = S_POLL;
            end
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0; stat_q <= '0; dma_q <= '0;
            cmd_q <= '0; mode_q <= '0;
            end_data_q <= 1'b0; err_q <= 1'b0; tmo_q <= 1'b0;
        end else begin
            if (take) begin
                arg_q      <= req_arg;
                cmd_q      <= enc_cmd;
                mode_q     <= enc_mode;
                end_data_q <= enc_end;
                err_q      <= 1'b0;
                tmo_q      <= 1'b0;
            end
            if ((state_q == S_POLL) && bus_ack) begin
                stat_q <= bus_rdata;
                if (bus_rdata[ST_ERROR]) begin
                    err_q <= 1'b1;
                end else if (!bus_rdata[ST_DMA_STOP] && !poll_hit && tmr_last) begin
                    err_q <= 1'b1;
                    tmo_q <= 1'b1;
                end
            end
            if ((state_q == S_DMARD) && bus_ack) dma_q <= bus_rdata;
            if ((state_q == S_DMAWR) && bus_ack && !saved_hit && tmr_last) begin
                err_q <= 1'b1;
                tmo_q <= 1'b1;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_size  = SZ_WORD;
        bus_addr  = '0;
        bus_wdata = '0;
        done      = 1'b0;
        done_err  = 1'b0;
        done_tmo  = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_CLR:    begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(OFF_ISTAT);  bus_wdata = 32'hFFFF_FFFF; end
            S_SIGEN:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(OFF_SIG_EN); end
            S_ARG:    begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(OFF_ARG);    bus_wdata = arg_q; end
            S_MODE:   begin bus_req = 1'b1; bus_we = 1'b1; bus_size = SZ_HALF; bus_addr = ADDR_W'(OFF_XFER); bus_wdata = {16'h0, mode_q}; end
            S_CMD:    begin bus_req = 1'b1; bus_we = 1'b1; bus_size = SZ_HALF; bus_addr = ADDR_W'(OFF_CMD);  bus_wdata = {16'h0, cmd_q}; end
            S_POLL:   begin bus_req = 1'b1; bus_addr = ADDR_W'(OFF_ISTAT); end
            S_STATBK: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(OFF_ISTAT); bus_wdata = stat_q; end
            S_DMARD:  begin bus_req = 1'b1; bus_addr = ADDR_W'(OFF_DMA_ADDR); end
            S_DMAWR:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(OFF_DMA_ADDR); bus_wdata = dma_q; end
            S_DONE:   begin done = 1'b1; done_err = err_q; done_tmo = tmo_q; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/sdcmd_issue_engine_chk.sv
module sdcmd_issue_engine_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack,
    input logic              done,
    input logic              done_err,
    input logic              done_tmo
);
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_size) && $stable(bus_wdata)));

    assert_idle_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_tmo_is_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_tmo || done_err) |-> done && (!done_tmo || done_err));

    assert_cmd_halfword_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == ADDR_W'(8'h0E)) |-> (bus_we && bus_size == 2'd1));

    assert_mode_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == ADDR_W'(8'h0C)) |->
            (bus_we && bus_size == 2'd1 && (bus_wdata == 32'h0 || bus_wdata == 32'h37)));

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && !req_ready));
endmodule

bind sdcmd_issue_engine sdcmd_issue_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_req(bus_req),
    .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .done(done),
    .done_err(done_err), .done_tmo(done_tmo)
);

// File: tb/sdcmd_issue_engine_tb_top.sv
module sdcmd_issue_engine_tb_top;
    localparam int AW = 8;
    localparam int TW = 4;

    typedef struct {
        bit        we;
        bit [1:0]  sz;
        bit [7:0]  addr;
        bit [31:0] wd;
    } acc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [7:0]  req_index = '0;
    logic [31:0] req_arg = '0;
    logic [4:0]  req_rsp = '0;
    logic req_data = 1'b0;
    logic [TW-1:0] timeout_limit = '0;
    logic bus_req, bus_we;
    logic [1:0] bus_size;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic done, done_err, done_tmo;

    int tests = 0;
    int fails = 0;
    int lat = 0;
    int wcnt = 0;
    int cycles = 0;
    acc_t acc_q[$];
    bit [31:0] stat_q[$];
    bit [31:0] script[$];
    bit [31:0] dma_val = 32'h8000_1200;

    always #2 clk = ~clk;

    sdcmd_issue_engine #(.ADDR_W(AW), .TMO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_arg(req_arg), .req_rsp(req_rsp), .req_data(req_data),
        .timeout_limit(timeout_limit), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done),
        .done_err(done_err), .done_tmo(done_tmo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Bus responder and scoreboard monitor
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                acc_t e;
                wcnt = 0;
                if (acc_q.size() == 0) begin
                    chk(0, "R10", "unexpected access addr", bus_addr, 0);
                end else begin
                    e = acc_q.pop_front();
                    chk(bus_we == e.we && bus_size == e.sz && bus_addr == e.addr,
                        e.we ? "R3/R4/R5/R8 write" : "R6/R8 read", "kind/size/addr",
                        {bus_we, bus_size, bus_addr}, {e.we, e.sz, e.addr});
                    if (e.we)
                        chk(bus_wdata == e.wd, "R3/R4/R5/R8", "write data", bus_wdata, e.wd);
                end
                if (!bus_we && bus_addr == 8'h30)
                    bus_rdata = (stat_q.size() != 0) ? stat_q.pop_front() : 32'h0;
                else if (!bus_we && bus_addr == 8'h00)
                    bus_rdata = dma_val;
                else
                    bus_rdata = 32'h0;
                bus_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    function automatic acc_t mk(bit we, bit [1:0] sz, bit [7:0] a, bit [31:0] d);
        acc_t r;
        r.we = we; r.sz = sz; r.addr = a; r.wd = d;
        return r;
    endfunction

    task automatic issue(input string name, input bit [7:0] idx, input bit [31:0] arg,
                         input bit [4:0] fl, input bit dat, input int lim, input int l);
        bit [7:0] f;
        bit end_dat, exp_err, exp_tmo;
        int polls, eff, guard;
        f = 8'h00;
        if (!fl[0])      f[1:0] = 2'd0;
        else if (fl[1])  f[1:0] = 2'd1;
        else if (fl[3])  f[1:0] = 2'd3;
        else             f[1:0] = 2'd2;
        if (fl[2]) f = f + 8'h08;
        if (fl[4]) f = f + 8'h10;
        if (dat)   f = f + 8'h20;
        end_dat = fl[3] | dat;
        eff = (lim < 1) ? 1 : lim;
        acc_q.push_back(mk(1, 2, 8'h30, 32'hFFFF_FFFF));
        acc_q.push_back(mk(1, 2, 8'h38, 32'h0));
        acc_q.push_back(mk(1, 2, 8'h08, arg));
        acc_q.push_back(mk(1, 1, 8'h0C, dat ? 32'h37 : 32'h0));
        acc_q.push_back(mk(1, 1, 8'h0E, {16'h0, idx, f}));
        exp_err = 0; exp_tmo = 0; polls = 0;
        foreach (script[i]) begin
            bit [31:0] s;
            s = script[i];
            acc_q.push_back(mk(0, 2, 8'h30, 32'h0));
            stat_q.push_back(s);
            if (s[15]) begin exp_err = 1; break; end
            if (s[3]) begin
                acc_q.push_back(mk(1, 2, 8'h30, s));
                acc_q.push_back(mk(0, 2, 8'h00, 32'h0));
                acc_q.push_back(mk(1, 2, 8'h00, dma_val));
            end
            if (end_dat ? s[1] : s[0]) break;
            polls++;
            if (polls >= eff) begin exp_err = 1; exp_tmo = 1; break; end
        end
        lat = l;
        @(negedge clk);
        req_index = idx; req_arg = arg; req_rsp = fl; req_data = dat;
        timeout_limit = TW'(lim);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2", {name, " ready low while busy"}, req_ready, 0);
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        chk(done == 1'b1, "R11", {name, " done seen"}, done, 1);
        chk(done_err == exp_err, exp_tmo ? "R9" : (exp_err ? "R7" : "R6"),
            {name, " done_err"}, done_err, exp_err);
        chk(done_tmo == exp_tmo, "R9", {name, " done_tmo"}, done_tmo, exp_tmo);
        chk(acc_q.size() == 0, "R7", {name, " accesses left over"}, acc_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", {name, " done one cycle"}, done, 0);
        chk(req_ready == 1'b1, "R2", {name, " ready after done"}, req_ready, 1);
        acc_q.delete();
        stat_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(bus_req == 1'b0, "R1", "reset bus_req", bus_req, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0, "R1", "idle after reset", bus_req, 0);

        // R1-type short response, completes on bit0 (R5 R6)
        script = '{32'h0, 32'h1};
        issue("sel", 8'd7, 32'h1000_0000, 5'b10101, 0, 10, 0);
        // busy response: bit0 must not complete, bit1 does (R6)
        script = '{32'h1, 32'h2};
        issue("busy", 8'd6, 32'h03B3_0100, 5'b11101, 0, 10, 1);
        // long response (R5)
        script = '{32'h1};
        issue("long", 8'd9, 32'h1000_0000, 5'b00111, 0, 10, 2);
        // present only
        script = '{32'h1};
        issue("plain", 8'd1, 32'h40FF_8080, 5'b00001, 0, 10, 0);
        // no response
        script = '{32'h1};
        issue("none", 8'd0, 32'h0, 5'b00000, 0, 10, 1);
        // data read with boundary stops, last one together with data-end (R4 R8)
        dma_val = 32'h8004_0000;
        script = '{32'h1, 32'h8, 32'h0, 32'hA};
        issue("data", 8'd18, 32'h0000_0200, 5'b10101, 1, 10, 1);
        // error with completion bits also set (R7)
        script = '{32'h0, 32'h8003};
        issue("err", 8'd7, 32'h0, 5'b10101, 0, 10, 0);
        // timeout after three empty polls (R9)
        script = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
        issue("tmo3", 8'd13, 32'h1000_0000, 5'b10101, 0, 3, 0);
        // limit 0 behaves as 1 (R9)
        script = '{32'h0, 32'h0};
        issue("tmo0", 8'd13, 32'h1000_0000, 5'b10101, 0, 0, 2);
        // boundary stop counts as a poll when no completion follows (R8 R9)
        dma_val = 32'h8008_0000;
        script = '{32'h8, 32'h0, 32'h0};
        issue("dmatmo", 8'd18, 32'h0000_0400, 5'b10101, 1, 2, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule